// File: doc/BRIEF.md
# Almost-Empty / Almost-Full Offset Programmer

This block holds the two threshold offsets that a FIFO's flag logic compares its fill level against: one for the almost-empty flag and one for the almost-full flag. Both are continuously presented on output ports for the comparators. During master reset both offsets are loaded with one of eight preset values. The preset is chosen by the load pin together with two preset-select pins. After reset, software or a controller can rewrite the offsets in the write clock domain. It can do so one bit at a time through a serial input, or a whole word at a time from the data bus.

In the read clock domain the offsets can be read back word by word onto a read-back bus. A load qualifier gates every programming and read-back access. While the qualifier is high, the ordinary FIFO write and read strobes are withheld from the storage array. The read-back path is a valid-only stream with no back-pressure. Each accepted read access produces exactly one `rb_valid` cycle, and the consumer must take the word in that cycle. The offset width must be a power of two.

Top module: `ofs_prog_top`

## Requirements
- R1: While `mrst` is high at a `wclk` edge, both offsets become 2^(k+3)-1, where k = {`load`,`psel[1]`,`psel[0]`} read as an unsigned 3-bit number, giving 7 for k=0 and 1023 for k=7.
- R2: Master reset returns the write-side word selector, the read-side word selector and the serial bit position to their start: the next word written or read is the almost-empty offset, and the next serial bit lands in almost-empty bit 0.
- R3: With `load` and `wr_en` high at a `wclk` edge, `din` is stored in one offset register. Successive parallel writes alternate almost-empty, almost-full, almost-empty, and so on.
- R4: With `load` and `ser_en` high and `wr_en` low at a `wclk` edge, `ser_in` is stored into one bit. The n-th serial bit after reset fills almost-empty bit n for n < W and almost-full bit n-W for W ≤ n < 2W. After 2W bits the position wraps to almost-empty bit 0.
- R5: When `wr_en` and `ser_en` are both high with `load`, only the parallel write takes place, and the serial position does not advance.
- R6: Without `load`, `wr_en` and `ser_en` leave both offsets unchanged.
- R7: With `load` and `rd_en` high at an `rclk` edge, `rb_data` takes the almost-empty offset, then the almost-full offset on the next such access, alternating. `rb_valid` is high for exactly the cycle after each access.
- R8: `rb_data` holds its value at every `rclk` edge without a read-back access.
- R9: `fifo_wr_ok` equals `wr_en` and `fifo_rd_ok` equals `rd_en` while `load` is low. Both are low while `load` is high.
- R10: `ae_ofs` and `af_ofs` show the stored offsets at all times, the same values whether they were loaded serially or in parallel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst | input | 1 | Synchronous master reset, active high, held for at least one edge of each clock |
| load | input | 1 | Offset access qualifier; also preset select MSB during reset |
| psel | input | 2 | Preset select low bits, used during reset |
| wr_en | input | 1 | Write strobe |
| din | input | W | Parallel offset data |
| ser_en | input | 1 | Serial shift enable |
| ser_in | input | 1 | Serial offset data bit |
| rd_en | input | 1 | Read strobe |
| rb_data | output | W | Read-back offset word |
| rb_valid | output | 1 | Read-back word valid, one cycle per access |
| ae_ofs | output | W | Almost-empty offset to flag logic |
| af_ofs | output | W | Almost-full offset to flag logic |
| fifo_wr_ok | output | 1 | Write strobe passed to FIFO storage |
| fifo_rd_ok | output | 1 | Read strobe passed to FIFO storage |

## Verification
The assertions assume that `mrst` is seen by both clocks. They also assume the offsets are not rewritten in the same window in which they are read back, because the read side samples write-domain registers without synchronisation. The stimulus runs both clocks from one 50 MHz source. It changes inputs only at falling edges, and it keeps write and read-back phases apart. Every preset code, two serial patterns and interleaved parallel writes are swept, and the expected words are computed arithmetically.

// File: rtl/ofs_pkg.sv
package ofs_pkg;
  // Preset offset value for reset-time code k: 2^(k+base)-1
  function automatic int unsigned preset_ofs(input logic [2:0] k, input int unsigned base);
    return (32'd1 << (32'(k) + base)) - 32'd1;
  endfunction
endpackage

// File: rtl/ofs_wr_path.sv
module ofs_wr_path #(
  parameter int W = 16,
  parameter int PRESET_BASE = 3
) (
  input  logic         wclk,
  input  logic         mrst,
  input  logic         load,
  input  logic [1:0]   psel,
  input  logic         wr_en,
  input  logic [W-1:0] din,
  input  logic         ser_en,
  input  logic         ser_in,
  output logic [W-1:0] ae_q,
  output logic [W-1:0] af_q
);
  localparam int IW = $clog2(W);
  localparam int SW = IW + 1;

  logic [W-1:0]  preset_w;
  logic          wsel;
  logic [SW-1:0] sbit;
  logic [IW-1:0] sidx;
  logic          par_go, ser_go;

  assign preset_w = W'(ofs_pkg::preset_ofs({load, psel}, PRESET_BASE));
  assign par_go   = load & wr_en;
  assign ser_go   = load & ser_en & ~wr_en;
  assign sidx     = sbit[IW-1:0];

  always_ff @(posedge wclk) begin
    if (mrst) begin
      ae_q <= preset_w;
      af_q <= preset_w;
      wsel <= 1'b0;
      sbit <= '0;
    end else if (par_go) begin
      if (!wsel) ae_q <= din;
      else       af_q <= din;
      wsel <= ~wsel;
    end else if (ser_go) begin
      if (!sbit[IW]) ae_q[sidx] <= ser_in;
      else           af_q[sidx] <= ser_in;
      sbit <= sbit + 1'b1;
    end
  end
endmodule

// File: rtl/ofs_rd_path.sv
module ofs_rd_path #(
  parameter int W = 16
) (
  input  logic         rclk,
  input  logic         mrst,
  input  logic         load,
  input  logic         rd_en,
  input  logic [W-1:0] ae_q,
  input  logic [W-1:0] af_q,
  output logic [W-1:0] rb_data,
  output logic         rb_valid
);
  logic rsel;

  always_ff @(posedge rclk) begin
    if (mrst) begin
      rsel     <= 1'b0;
      rb_valid <= 1'b0;
      rb_data  <= '0;
    end else begin
      rb_valid <= load & rd_en;
      if (load && rd_en) begin
        rb_data <= rsel ? af_q : ae_q;
        rsel    <= ~rsel;
      end
    end
  end
endmodule

// File: rtl/ofs_prog_top.sv
module ofs_prog_top #(
  parameter int W = 16,
  parameter int PRESET_BASE = 3
) (
  input  logic         wclk,
  input  logic         rclk,
  input  logic         mrst,
  input  logic         load,
  input  logic [1:0]   psel,
  input  logic         wr_en,
  input  logic [W-1:0] din,
  input  logic         ser_en,
  input  logic         ser_in,
  input  logic         rd_en,
  output logic [W-1:0] rb_data,
  output logic         rb_valid,
  output logic [W-1:0] ae_ofs,
  output logic [W-1:0] af_ofs,
  output logic         fifo_wr_ok,
  output logic         fifo_rd_ok
);
  logic [W-1:0] ae_q, af_q;

  ofs_wr_path #(.W(W), .PRESET_BASE(PRESET_BASE)) u_wr (
    .wclk(wclk), .mrst(mrst), .load(load), .psel(psel),
    .wr_en(wr_en), .din(din), .ser_en(ser_en), .ser_in(ser_in),
    .ae_q(ae_q), .af_q(af_q)
  );

  ofs_rd_path #(.W(W)) u_rd (
    .rclk(rclk), .mrst(mrst), .load(load), .rd_en(rd_en),
    .ae_q(ae_q), .af_q(af_q), .rb_data(rb_data), .rb_valid(rb_valid)
  );

  assign ae_ofs     = ae_q;
  assign af_ofs     = af_q;
  assign fifo_wr_ok = wr_en & ~load;
  assign fifo_rd_ok = rd_en & ~load;
endmodule

// File: rtl/ofs_prog_chk.sv
module ofs_prog_chk #(
  parameter int W = 16,
  parameter int PRESET_BASE = 3
) (
  input logic         wclk,
  input logic         rclk,
  input logic         mrst,
  input logic         load,
  input logic [1:0]   psel,
  input logic         wr_en,
  input logic [W-1:0] din,
  input logic         ser_en,
  input logic         rd_en,
  input logic [W-1:0] rb_data,
  input logic         rb_valid,
  input logic [W-1:0] ae_ofs,
  input logic [W-1:0] af_ofs
);
  AST_PRESET_LOAD: assert property (@(posedge wclk)
    mrst |=> (ae_ofs == W'(ofs_pkg::preset_ofs({$past(load), $past(psel)}, PRESET_BASE))
              && af_ofs == ae_ofs)); // R1

  AST_PAR_STORE: assert property (@(posedge wclk) disable iff (mrst)
    (load && wr_en) |=> (ae_ofs == $past(din) || af_ofs == $past(din))); // R3

  AST_IDLE_HOLD: assert property (@(posedge wclk) disable iff (mrst)
    !(load && (wr_en || ser_en)) |=> ($stable(ae_ofs) && $stable(af_ofs))); // R6

  AST_RB_PULSE: assert property (@(posedge rclk) disable iff (mrst)
    (load && rd_en) |=> rb_valid); // R7

  AST_RB_QUIET: assert property (@(posedge rclk) disable iff (mrst)
    !(load && rd_en) |=> !rb_valid); // R7

  AST_RB_HOLD: assert property (@(posedge rclk) disable iff (mrst)
    !(load && rd_en) |=> $stable(rb_data)); // R8
endmodule

bind ofs_prog_top ofs_prog_chk #(.W(W), .PRESET_BASE(PRESET_BASE)) u_chk (
  .wclk(wclk), .rclk(rclk), .mrst(mrst), .load(load), .psel(psel),
  .wr_en(wr_en), .din(din), .ser_en(ser_en), .rd_en(rd_en),
  .rb_data(rb_data), .rb_valid(rb_valid), .ae_ofs(ae_ofs), .af_ofs(af_ofs)
);

// File: tb/test_ofs_prog_top.sv
module test_ofs_prog_top;
  localparam int W = 16;

  logic clk = 1'b0;
  logic mrst, load, wr_en, ser_en, ser_in, rd_en;
  logic [1:0] psel;
  logic [W-1:0] din;
  logic [W-1:0] rb_data, ae_ofs, af_ofs;
  logic rb_valid, fifo_wr_ok, fifo_rd_ok;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ofs_prog_top #(.W(W), .PRESET_BASE(3)) i_ofs_prog_top (
    .wclk(clk), .rclk(clk), .mrst(mrst), .load(load), .psel(psel),
    .wr_en(wr_en), .din(din), .ser_en(ser_en), .ser_in(ser_in), .rd_en(rd_en),
    .rb_data(rb_data), .rb_valid(rb_valid), .ae_ofs(ae_ofs), .af_ofs(af_ofs),
    .fifo_wr_ok(fifo_wr_ok), .fifo_rd_ok(fifo_rd_ok)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [2:0] k);
    @(negedge clk);
    mrst = 1; load = k[2]; psel = k[1:0];
    wr_en = 0; ser_en = 0; rd_en = 0; din = '0; ser_in = 0;
    @(negedge clk); @(negedge clk);
    mrst = 0; load = 0; psel = 0;
  endtask

  task automatic pwrite(input logic [W-1:0] v);
    @(negedge clk); load = 1; wr_en = 1; din = v;
    @(negedge clk); load = 0; wr_en = 0;
  endtask

  task automatic sshift(input logic [2*W-1:0] p);
    for (int i = 0; i < 2*W; i++) begin
      @(negedge clk); load = 1; ser_en = 1; ser_in = p[i];
    end
    @(negedge clk); load = 0; ser_en = 0;
  endtask

  task automatic rback(input string req, input logic [W-1:0] exp);
    @(negedge clk); load = 1; rd_en = 1;
    @(negedge clk); load = 0; rd_en = 0;
    check({req, " data"}, rb_data, exp);
    check({req, " valid"}, rb_valid, 1'b1);
  endtask

  initial begin
    #4000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [2*W-1:0] pats [2];
    pats[0] = 32'hA5C3_1E69;
    pats[1] = 32'h0F0F_F0F0;
    mrst = 1; load = 0; psel = 0; wr_en = 0; ser_en = 0; ser_in = 0; rd_en = 0; din = 0;

    // R1: sweep every preset code
    for (int k = 0; k < 8; k++) begin
      do_reset(3'(k));
      check("R1 ae preset", ae_ofs, (32'd1 << (k + 3)) - 1);
      check("R1 af preset", af_ofs, (32'd1 << (k + 3)) - 1);
      check("R8 rb_valid after reset", rb_valid, 1'b0);
    end

    // R9: strobe gating
    @(negedge clk); wr_en = 1; rd_en = 1; load = 0; #1;
    check("R9 wr pass", fifo_wr_ok, 1'b1);
    check("R9 rd pass", fifo_rd_ok, 1'b1);
    // R6: writes without load touch nothing
    din = 16'h1234; ser_en = 1; ser_in = 0;
    @(negedge clk);
    check("R6 ae unchanged", ae_ofs, 16'd1023);
    check("R6 af unchanged", af_ofs, 16'd1023);
    load = 1; wr_en = 1; rd_en = 1; ser_en = 0; #1;
    check("R9 wr blocked", fifo_wr_ok, 1'b0);
    check("R9 rd blocked", fifo_rd_ok, 1'b0);
    load = 0; wr_en = 0; rd_en = 0;

    // R3: alternating parallel writes
    do_reset(3'd0);
    for (int i = 0; i < 6; i++) begin
      logic [W-1:0] v;
      v = W'(16'h0101 * (i + 3) ^ 16'h8000);
      pwrite(v);
      if (i % 2 == 0) check("R3 ae write", ae_ofs, v);
      else            check("R3 af write", af_ofs, v);
    end
    // R7: read-back ordering after parallel loads (last pair i=4,5)
    rback("R7 rb ae", W'(16'h0101 * 7 ^ 16'h8000));
    @(negedge clk);
    check("R7 valid single cycle", rb_valid, 1'b0);
    check("R8 data held", rb_data, W'(16'h0101 * 7 ^ 16'h8000));
    rback("R7 rb af", W'(16'h0101 * 8 ^ 16'h8000));
    rback("R7 rb wrap ae", W'(16'h0101 * 7 ^ 16'h8000));

    // R2: selectors cleared by reset (write side left at af, read side at af)
    pwrite(16'h00AA);
    do_reset(3'd2);
    pwrite(16'h5555);
    check("R2 write selector restart", ae_ofs, 16'h5555);
    check("R2 af keeps preset", af_ofs, 16'd31);
    rback("R2 read selector restart", 16'h5555);

    // R4 / R10: serial patterns, checked on outputs and read-back
    for (int j = 0; j < 2; j++) begin
      do_reset(3'd5);
      sshift(pats[j]);
      check("R4 ae serial", ae_ofs, pats[j][W-1:0]);
      check("R4 af serial", af_ofs, pats[j][2*W-1:W]);
      rback("R10 rb ae serial", pats[j][W-1:0]);
      rback("R10 rb af serial", pats[j][2*W-1:W]);
    end
    // R4: wrap after 2W bits, next bit lands in ae bit 0
    @(negedge clk); load = 1; ser_en = 1; ser_in = ~pats[1][0];
    @(negedge clk); load = 0; ser_en = 0;
    check("R4 wrap", ae_ofs, {pats[1][W-1:1], ~pats[1][0]});

    // R5: parallel wins over serial; serial position stays
    do_reset(3'd1);
    @(negedge clk); load = 1; wr_en = 1; ser_en = 1; ser_in = 1; din = 16'hC0DE;
    @(negedge clk); load = 0; wr_en = 0; ser_en = 0;
    check("R5 parallel taken", ae_ofs, 16'hC0DE);
    check("R5 af untouched", af_ofs, 16'd15);
    @(negedge clk); load = 1; ser_en = 1; ser_in = 1;
    @(negedge clk); load = 0; ser_en = 0;
    check("R5 serial pos not advanced", ae_ofs, 16'hC0DF);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule